// File: doc/BRIEF.md
# Microcoded Execute Datapath

This block is the execute stage of a microcoded 8-bit processor engine. On every clock it takes one 32-bit microinstruction. It picks two 16-bit operands from a fixed map of sources and runs one ALU operation on them. The result goes to one selected destination register. The sources are four 16-bit scratch registers, the 8-bit accumulator and index registers, the program counter, the stack pointer, the flag byte, the address register, the incoming memory byte, a status word, the output control register and the instruction's immediate. A sequencer outside the block fetches the microinstructions and decides branches. For its zero tests it uses the latched last ALU result that this block drives out.

The status word collects several signals for the microcode. It carries the byte carry and byte overflow of the most recent addition. It carries a latched request from a falling non-maskable interrupt line, which the microcode acknowledges. It also carries the maskable interrupt line, masked by the interrupt-disable flag. Toward memory the block drives only an address, a write byte, a read/write-bar level and a write strobe.

There is no handshake. A new microinstruction is accepted on every clock and nothing can push back. The sequencer must hold a no-write kind (0 or 1) on the bus whenever it has nothing to issue.

Top module: `ucode_exec_dp`

## Requirements
- R1: The microinstruction fields are: kind in bits 31:28, destination code in 27:24, first-operand code in 23:20, second-operand code in 19:16 and immediate in 15:0. Source codes 0-3 are scratch registers 0-3. Codes 4, 5 and 6 are the accumulator, X and Y, zero-extended. Code 9 is the flag byte, zero-extended. Code A is the address register. Code C is the status word. Code D is the output control register, zero-extended.
- R2: Source code 8 gives the stack pointer with 0x01 in the high byte. Code B gives the memory input byte copied into both bytes. Code E gives zero on both operands. Code F gives zero as the first operand and the immediate as the second. Code 7 gives the program counter as the first operand and the program counter with its bytes swapped as the second.
- R3: Kind 2 adds, 3 ANDs, 4 ORs, 5 XORs and 6 shifts the first operand right by one with a zero fill. Every other kind yields 0xEEEE.
- R4: An addition sets the byte carry (status bit 0) to the carry out of bit 7 of the low-byte sum. It sets the byte overflow (status bit 6) to that carry XOR the carry into bit 7. Both values hold through all non-add cycles.
- R5: The destination and the last-result output `alu_last` are written only when the kind is above 1. Kinds 0 and 1 leave all state unchanged.
- R6: The destinations accumulator (4), X (5), Y (6), stack pointer (8) and write byte (B) keep only the low result byte. The output control register (D) keeps the low 5 bits. Scratch registers, the program counter (7) and the address register (A) keep all 16 bits.
- R7: Destination 9 stores the low result byte into the flags with bits 5 and 4 forced to 1.
- R8: Destination codes C, E and F change no register.
- R9: Status bit 5 is 1 exactly when `irq_n` is low and flag bit 2 is 0. It follows the inputs in the same cycle.
- R10: A high-to-low change of `nmi_n` between two clocks sets status bit 3 at the second clock. A clock with `nmi_ack` high clears it, and the clear takes priority over a new set.
- R11: `rd_wr_n` is bit 0 of the output control register. `mem_we` is high when the kind is 1, the second-operand field is 3 and `rd_wr_n` is 0. The write goes to `mem_addr` with the data `mem_wdata`.
- R12: A synchronous reset clears all state, except that the program counter becomes 0x0400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uinst | input | 32 | Microinstruction executed this cycle |
| mem_rdata | input | 8 | Byte returned by memory |
| irq_n | input | 1 | Maskable interrupt line, active low |
| nmi_n | input | 1 | Non-maskable interrupt line, active low, edge sensed |
| nmi_ack | input | 1 | Acknowledge that clears the latched NMI request |
| mem_addr | output | 16 | Address register |
| mem_wdata | output | 8 | Write-byte register |
| rd_wr_n | output | 1 | Read (1) / write (0) level |
| mem_we | output | 1 | Memory write strobe |
| alu_last | output | 16 | Last ALU result written back |

## Verification
Any register can be read within one cycle through `alu_last`: OR the register with code E and send the result to destination C. A corrupted register therefore shows up as a wrong `alu_last` on the first readback after the fault. Carry, overflow and NMI faults show the same way when the status word is read. A wrong control bit shows at once on `rd_wr_n` and `mem_we`. The bench compares every output against its reference model after every clock and sweeps all sources at the points where state builds up. A fault that has no visible effect yet is still caught at the next sweep.

// File: rtl/ued_pkg.sv
package ued_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 5;
  localparam int SCR_N  = 4;
  localparam int SEL_W  = 4;
  localparam int UI_W   = 4 * SEL_W + WORD_W;

  localparam logic [WORD_W-1:0] BAD_KIND_WORD = 16'hEEEE;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t K_BRANCH = 4'd1;
  localparam sel_t K_ADD    = 4'd2;
  localparam sel_t K_AND    = 4'd3;
  localparam sel_t K_OR     = 4'd4;
  localparam sel_t K_XOR    = 4'd5;
  localparam sel_t K_SHR    = 4'd6;

  localparam sel_t S_ACC  = 4'd4;
  localparam sel_t S_IX   = 4'd5;
  localparam sel_t S_IY   = 4'd6;
  localparam sel_t S_PC   = 4'd7;
  localparam sel_t S_SP   = 4'd8;
  localparam sel_t S_FLG  = 4'd9;
  localparam sel_t S_ADR  = 4'd10;
  localparam sel_t S_DAT  = 4'd11;
  localparam sel_t S_STS  = 4'd12;
  localparam sel_t S_CTL  = 4'd13;
  localparam sel_t S_ZERO = 4'd14;
  localparam sel_t S_IMM  = 4'd15;

  localparam sel_t COND_STORE = 4'd3;

  typedef struct packed {
    sel_t              kind;
    sel_t              dst;
    sel_t              src0;
    sel_t              src1;
    logic [WORD_W-1:0] imm;
  } uinst_t;
endpackage

// File: rtl/ued_opnd_sel.sv
module ued_opnd_sel
  import ued_pkg::*;
#(
  parameter bit SIDE_B = 1'b0
) (
  input  sel_t                        sel,
  input  logic [SCR_N-1:0][WORD_W-1:0] scr,
  input  logic [BYTE_W-1:0]           acc_r,
  input  logic [BYTE_W-1:0]           ix_r,
  input  logic [BYTE_W-1:0]           iy_r,
  input  logic [BYTE_W-1:0]           sp_r,
  input  logic [BYTE_W-1:0]           flg_r,
  input  logic [BYTE_W-1:0]           din,
  input  logic [WORD_W-1:0]           pc_r,
  input  logic [WORD_W-1:0]           adr_r,
  input  logic [WORD_W-1:0]           sts,
  input  logic [CTRL_W-1:0]           ctl_r,
  input  logic [WORD_W-1:0]           f_val,
  output logic [WORD_W-1:0]           opnd
);
  localparam int HI_W  = WORD_W - BYTE_W;
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;
  localparam logic [HI_W-1:0] STACK_PAGE = HI_W'(1);

  logic [WORD_W-1:0] pc_view;

  generate
    if (SIDE_B) begin : g_swap
      assign pc_view = {pc_r[BYTE_W-1:0], pc_r[WORD_W-1:BYTE_W]};
    end else begin : g_plain
      assign pc_view = pc_r;
    end
  endgenerate

  always_comb begin
    opnd = '0;
    if (sel < sel_t'(SCR_N)) begin
      opnd = scr[sel[SCR_IW-1:0]];
    end else begin
      case (sel)
        S_ACC:   opnd = {{HI_W{1'b0}}, acc_r};
        S_IX:    opnd = {{HI_W{1'b0}}, ix_r};
        S_IY:    opnd = {{HI_W{1'b0}}, iy_r};
        S_PC:    opnd = pc_view;
        S_SP:    opnd = {STACK_PAGE, sp_r};
        S_FLG:   opnd = {{HI_W{1'b0}}, flg_r};
        S_ADR:   opnd = adr_r;
        S_DAT:   opnd = {din, din};
        S_STS:   opnd = sts;
        S_CTL:   opnd = {{(WORD_W-CTRL_W){1'b0}}, ctl_r};
        S_IMM:   opnd = f_val;
        default: opnd = '0;
      endcase
    end
  end
endmodule

// File: rtl/ued_alu.sv
module ued_alu
  import ued_pkg::*;
(
  input  sel_t              kind,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y,
  output logic              c8,
  output logic              ov8
);
  logic [BYTE_W:0]   lo_sum;
  logic [BYTE_W-1:0] lo7_sum;

  always_comb begin
    lo_sum  = {1'b0, a[BYTE_W-1:0]} + {1'b0, b[BYTE_W-1:0]};
    lo7_sum = {1'b0, a[BYTE_W-2:0]} + {1'b0, b[BYTE_W-2:0]};
    c8      = lo_sum[BYTE_W];
    ov8     = lo_sum[BYTE_W] ^ lo7_sum[BYTE_W-1];
  end

  always_comb begin
    case (kind)
      K_ADD:   y = a + b;
      K_AND:   y = a & b;
      K_OR:    y = a | b;
      K_XOR:   y = a ^ b;
      K_SHR:   y = {1'b0, a[WORD_W-1:1]};
      default: y = BAD_KIND_WORD;
    endcase
  end
endmodule

// File: rtl/ued_event_cond.sv
module ued_event_cond
  import ued_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              nmi_ack,
  input  logic              iflag,
  input  logic              c8,
  input  logic              ov8,
  output logic [WORD_W-1:0] status
);
  localparam int B_CARRY = 0;
  localparam int B_NMI   = 3;
  localparam int B_IRQ   = 5;
  localparam int B_OVF   = 6;

  logic nmi_prev;
  logic nmi_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b1;
      nmi_lat  <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      if (nmi_ack)
        nmi_lat <= 1'b0;
      else if (nmi_prev && !nmi_n)
        nmi_lat <= 1'b1;
    end
  end

  always_comb begin
    status          = '0;
    status[B_CARRY] = c8;
    status[B_NMI]   = nmi_lat;
    status[B_IRQ]   = !irq_n && !iflag;
    status[B_OVF]   = ov8;
  end

  assert_nmi_clear_R10: assert property (@(posedge clk) disable iff (rst)
    nmi_ack |=> !status[B_NMI]);

  assert_nmi_edge_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(nmi_n) && !nmi_ack) |=> status[B_NMI]);
endmodule

// File: rtl/ucode_exec_dp.sv
module ucode_exec_dp
  import ued_pkg::*;
#(
  parameter logic [15:0] PC_RST = 16'h0400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] uinst,
  input  logic [7:0]  mem_rdata,
  input  logic        irq_n,
  input  logic        nmi_n,
  input  logic        nmi_ack,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        rd_wr_n,
  output logic        mem_we,
  output logic [15:0] alu_last
);
  localparam int FLG_FORCE_LO = 4;
  localparam int FLG_FORCE_HI = 5;
  localparam int FLG_IDIS     = 2;

  uinst_t u;
  assign u = uinst_t'(uinst);

  logic [SCR_N-1:0][WORD_W-1:0] scr_q;
  logic [BYTE_W-1:0] acc_q, ix_q, iy_q, sp_q, flg_q, wd_q;
  logic [WORD_W-1:0] pc_q, adr_q, last_q;
  logic [CTRL_W-1:0] ctl_q;
  logic              c8_q, ov8_q;

  logic [WORD_W-1:0] sts, op0, op1, alu_y;
  logic              alu_c8, alu_ov8;
  logic              wb_en;

  assign wb_en = (u.kind > K_BRANCH);

  ued_event_cond u_evt (
    .clk    (clk),
    .rst    (rst),
    .irq_n  (irq_n),
    .nmi_n  (nmi_n),
    .nmi_ack(nmi_ack),
    .iflag  (flg_q[FLG_IDIS]),
    .c8     (c8_q),
    .ov8    (ov8_q),
    .status (sts)
  );

  ued_opnd_sel #(.SIDE_B(1'b0)) u_sel0 (
    .sel(u.src0), .scr(scr_q), .acc_r(acc_q), .ix_r(ix_q), .iy_r(iy_q),
    .sp_r(sp_q), .flg_r(flg_q), .din(mem_rdata), .pc_r(pc_q), .adr_r(adr_q),
    .sts(sts), .ctl_r(ctl_q), .f_val('0), .opnd(op0)
  );

  ued_opnd_sel #(.SIDE_B(1'b1)) u_sel1 (
    .sel(u.src1), .scr(scr_q), .acc_r(acc_q), .ix_r(ix_q), .iy_r(iy_q),
    .sp_r(sp_q), .flg_r(flg_q), .din(mem_rdata), .pc_r(pc_q), .adr_r(adr_q),
    .sts(sts), .ctl_r(ctl_q), .f_val(u.imm), .opnd(op1)
  );

  ued_alu u_alu (
    .kind(u.kind),
    .a   (op0),
    .b   (op1),
    .y   (alu_y),
    .c8  (alu_c8),
    .ov8 (alu_ov8)
  );

  generate
    for (genvar i = 0; i < SCR_N; i++) begin : g_scr
      always_ff @(posedge clk) begin
        if (rst)
          scr_q[i] <= '0;
        else if (wb_en && u.dst == sel_t'(i))
          scr_q[i] <= alu_y;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      ix_q   <= '0;
      iy_q   <= '0;
      sp_q   <= '0;
      flg_q  <= '0;
      wd_q   <= '0;
      pc_q   <= PC_RST;
      adr_q  <= '0;
      ctl_q  <= '0;
      last_q <= '0;
    end else if (wb_en) begin
      last_q <= alu_y;
      case (u.dst)
        S_ACC: acc_q <= alu_y[BYTE_W-1:0];
        S_IX:  ix_q  <= alu_y[BYTE_W-1:0];
        S_IY:  iy_q  <= alu_y[BYTE_W-1:0];
        S_PC:  pc_q  <= alu_y;
        S_SP:  sp_q  <= alu_y[BYTE_W-1:0];
        S_FLG: begin
          flg_q <= alu_y[BYTE_W-1:0];
          flg_q[FLG_FORCE_HI] <= 1'b1;
          flg_q[FLG_FORCE_LO] <= 1'b1;
        end
        S_ADR: adr_q <= alu_y;
        S_DAT: wd_q  <= alu_y[BYTE_W-1:0];
        S_CTL: ctl_q <= alu_y[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c8_q  <= 1'b0;
      ov8_q <= 1'b0;
    end else if (u.kind == K_ADD) begin
      c8_q  <= alu_c8;
      ov8_q <= alu_ov8;
    end
  end

  assign mem_addr  = adr_q;
  assign mem_wdata = wd_q;
  assign rd_wr_n   = ctl_q[0];
  assign alu_last  = last_q;
  assign mem_we    = (u.kind == K_BRANCH) && (u.src1 == COND_STORE) && !ctl_q[0];

  assert_last_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (u.kind <= K_BRANCH) |=> $stable(alu_last));

  assert_flags_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (wb_en && u.dst == S_FLG) |=> (flg_q[FLG_FORCE_HI:FLG_FORCE_LO] == 2'b11));

  assert_sp_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_en && u.dst == S_SP) |=> (sp_q == $past(alu_y[BYTE_W-1:0])));

  assert_rdwr_track_R11: assert property (@(posedge clk) disable iff (rst)
    (wb_en && u.dst == S_CTL) |=> (rd_wr_n == $past(alu_y[0])));

  assert_bad_kind_R3: assert property (@(posedge clk) disable iff (rst)
    (u.kind > K_SHR) |-> (alu_y == BAD_KIND_WORD));

  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (u.kind != K_ADD) |=> ($stable(c8_q) && $stable(ov8_q)));
endmodule

// File: tb/ucode_exec_dp_tb.sv
`timescale 1ns/1ps
module ucode_exec_dp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] uinst = 32'h0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        irq_n = 1'b1;
  logic        nmi_n = 1'b1;
  logic        nmi_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rd_wr_n;
  logic        mem_we;
  logic [15:0] alu_last;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ucode_exec_dp u_dut (
    .clk(clk), .rst(rst), .uinst(uinst), .mem_rdata(mem_rdata),
    .irq_n(irq_n), .nmi_n(nmi_n), .nmi_ack(nmi_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_wr_n(rd_wr_n),
    .mem_we(mem_we), .alu_last(alu_last)
  );

  // reference model state
  logic [15:0] m_scr [4];
  logic [7:0]  m_a, m_x, m_y, m_sp, m_flg, m_wd;
  logic [15:0] m_pc, m_adr, m_last;
  logic [4:0]  m_ctl;
  logic        m_c8, m_ov, m_nl, m_np;

  function automatic [31:0] mk(input int kind, input int dst, input int s0,
                               input int s1, input int imm);
    mk = {kind[3:0], dst[3:0], s0[3:0], s1[3:0], imm[15:0]};
  endfunction

  function automatic [15:0] m_status();
    logic [15:0] s = 16'h0;
    s[0] = m_c8;
    s[3] = m_nl;
    s[5] = (irq_n == 1'b0) && (m_flg[2] == 1'b0);
    s[6] = m_ov;
    return s;
  endfunction

  function automatic [15:0] m_src(input int code, input bit second);
    case (code)
      0, 1, 2, 3: return m_scr[code];
      4:  return {8'h00, m_a};
      5:  return {8'h00, m_x};
      6:  return {8'h00, m_y};
      7:  return second ? {m_pc[7:0], m_pc[15:8]} : m_pc;
      8:  return 16'h0100 + {8'h00, m_sp};
      9:  return {8'h00, m_flg};
      10: return m_adr;
      11: return {mem_rdata, mem_rdata};
      12: return m_status();
      13: return {11'h0, m_ctl};
      15: return second ? uinst[15:0] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) m_scr[i] = 16'h0;
    m_a = 0; m_x = 0; m_y = 0; m_sp = 0; m_flg = 0; m_wd = 0;
    m_pc = 16'h0400; m_adr = 0; m_last = 0; m_ctl = 0;
    m_c8 = 0; m_ov = 0; m_nl = 0; m_np = 1;
  endtask

  task automatic m_update(input logic [31:0] ui);
    int kind = int'(ui[31:28]);
    int dst = int'(ui[27:24]);
    int o0 = int'(m_src(int'(ui[23:20]), 1'b0));
    int o1 = int'(m_src(int'(ui[19:16]), 1'b1));
    int res;
    case (kind)
      2: begin
        res  = (o0 + o1) % 65536;
        m_c8 = ((o0 % 256) + (o1 % 256)) > 255;
        m_ov = m_c8 ^ (((o0 % 128) + (o1 % 128)) > 127);
      end
      3: res = o0 & o1;
      4: res = o0 | o1;
      5: res = o0 ^ o1;
      6: res = o0 / 2;
      default: res = 'hEEEE;
    endcase
    if (kind > 1) begin
      m_last = res[15:0];
      case (dst)
        0, 1, 2, 3: m_scr[dst] = res[15:0];
        4:  m_a   = res[7:0];
        5:  m_x   = res[7:0];
        6:  m_y   = res[7:0];
        7:  m_pc  = res[15:0];
        8:  m_sp  = res[7:0];
        9:  m_flg = res[7:0] | 8'h30;
        10: m_adr = res[15:0];
        11: m_wd  = res[7:0];
        13: m_ctl = res[4:0];
        default: ;
      endcase
    end
    if (nmi_ack) m_nl = 1'b0;
    else if (m_np && !nmi_n) m_nl = 1'b1;
    m_np = nmi_n;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ui, input string tag);
    logic exp_we;
    @(negedge clk);
    uinst = ui;
    #1;
    exp_we = (ui[31:28] == 4'd1) && (ui[19:16] == 4'd3) && (m_ctl[0] == 1'b0);
    chk(tag, "mem_we", {15'h0, mem_we}, {15'h0, exp_we});
    m_update(ui);
    @(posedge clk);
    #1;
    chk(tag, "alu_last", alu_last, m_last);
    chk(tag, "mem_addr", mem_addr, m_adr);
    chk(tag, "mem_wdata", {8'h0, mem_wdata}, {8'h0, m_wd});
    chk(tag, "rd_wr_n", {15'h0, rd_wr_n}, {15'h0, m_ctl[0]});
  endtask

  // read a source through alu_last: OR with zero into destination C
  task automatic rd(input int code, input string tag);
    step(mk(4, 12, code, 14, 0), tag);
  endtask

  task automatic sweep(input string tag);
    for (int c = 0; c < 14; c++) rd(c, tag);
  endtask

  task automatic ld(input int dst, input int val, input string tag);
    step(mk(4, dst, 14, 15, val), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R12: reset state at the ports
    chk("R12", "alu_last", alu_last, 16'h0000);
    chk("R12", "mem_addr", mem_addr, 16'h0000);
    chk("R12", "rd_wr_n", {15'h0, rd_wr_n}, 16'h0000);
    rd(7, "R12");
    chk("R12", "pc_reset", alu_last, 16'h0400);
    step(mk(4, 12, 14, 7, 0), "R2");
    chk("R2", "pc_swapped", alu_last, 16'h0004);
    sweep("R12");

    // R1/R6: load every register and read it back
    ld(0, 'h1234, "R1"); ld(1, 'h8080, "R1"); ld(2, 'h4040, "R1"); ld(3, 'hFFFF, "R1");
    ld(4, 'hABCD, "R6"); rd(4, "R6");
    chk("R6", "acc_low_byte", alu_last, 16'h00CD);
    ld(5, 'h1122, "R6"); ld(6, 'h33F4, "R6");
    ld(8, 'hBE77, "R6"); rd(8, "R2");
    chk("R2", "sp_page1", alu_last, 16'h0177);
    ld(10, 'hC0DE, "R6"); ld(11, 'h3399, "R6");
    chk("R6", "wdata_byte", {8'h0, mem_wdata}, 16'h0099);
    ld(7, 'h2468, "R6");
    mem_rdata = 8'h5A;
    rd(11, "R2");
    chk("R2", "data_dup", alu_last, 16'h5A5A);
    step(mk(4, 12, 15, 14, 'h7777), "R2");
    chk("R2", "f_first_zero", alu_last, 16'h0000);
    sweep("R1");

    // R3/R4: ALU kinds and byte flags
    step(mk(2, 12, 1, 1, 0), "R4");
    rd(12, "R4");
    chk("R4", "carry_ovf", alu_last, 16'h0041);
    step(mk(3, 3, 0, 3, 0), "R4");
    rd(12, "R4");
    chk("R4", "hold", alu_last, 16'h0041);
    step(mk(2, 12, 2, 2, 0), "R4");
    rd(12, "R4");
    chk("R4", "ovf_only", alu_last, 16'h0040);
    step(mk(2, 12, 0, 15, 'h00CC), "R4");
    step(mk(5, 0, 0, 15, 'h0F0F), "R3");
    step(mk(6, 1, 3, 14, 0), "R3");
    step(mk(4, 2, 0, 1, 0), "R3");
    step(mk(9, 2, 0, 1, 0), "R3");
    chk("R3", "bad_kind", alu_last, 16'hEEEE);
    step(mk(15, 3, 0, 1, 0), "R3");
    step(mk(7, 12, 0, 1, 0), "R3");

    // R5: kinds 0 and 1 leave everything alone
    step(mk(0, 0, 15, 15, 'h5555), "R5");
    step(mk(1, 4, 15, 15, 'h5555), "R5");
    chk("R5", "last_unchanged", alu_last, 16'hEEEE);

    // R8: no-write destinations
    step(mk(4, 12, 14, 15, 'h9999), "R8");
    step(mk(4, 14, 14, 15, 'h9999), "R8");
    step(mk(4, 15, 14, 15, 'h9999), "R8");
    sweep("R8");

    // R7/R9: flags forcing and IRQ masking
    ld(9, 'h0000, "R7"); rd(9, "R7");
    chk("R7", "flags_forced", alu_last, 16'h0030);
    irq_n = 1'b0;
    rd(12, "R9");
    chk("R9", "irq_seen", alu_last & 16'h0020, 16'h0020);
    ld(9, 'h0004, "R9");
    rd(12, "R9");
    chk("R9", "irq_masked", alu_last & 16'h0020, 16'h0000);
    irq_n = 1'b1;
    ld(9, 'h00C1, "R7");

    // R10: NMI edge latch and acknowledge
    nmi_n = 1'b0;
    rd(12, "R10");
    rd(12, "R10");
    chk("R10", "nmi_set", alu_last & 16'h0008, 16'h0008);
    nmi_ack = 1'b1;
    rd(12, "R10");
    nmi_ack = 1'b0;
    rd(12, "R10");
    chk("R10", "nmi_cleared", alu_last & 16'h0008, 16'h0000);
    nmi_n = 1'b1; rd(12, "R10");
    nmi_n = 1'b0; nmi_ack = 1'b1; rd(12, "R10");
    nmi_ack = 1'b0; rd(12, "R10");
    chk("R10", "ack_wins", alu_last & 16'h0008, 16'h0000);
    nmi_n = 1'b1;

    // R11: read/write-bar and write strobe
    step(mk(1, 0, 0, 3, 0), "R11");
    ld(13, 'hFFFF, "R11"); rd(13, "R6");
    chk("R6", "ctl_5bit", alu_last, 16'h001F);
    chk("R11", "rd_wr_n_high", {15'h0, rd_wr_n}, 16'h0001);
    step(mk(1, 0, 0, 3, 0), "R11");
    step(mk(1, 0, 0, 2, 0), "R11");
    ld(13, 'h0002, "R11");
    step(mk(1, 0, 0, 3, 0), "R11");
    sweep("R11");

    // assorted mixes for broader coverage
    for (int i = 0; i < 40; i++) begin
      mem_rdata = 8'(i * 37 + 3);
      step(mk(2 + (i % 5), i % 14, (i * 3) % 16, (i * 5) % 16, i * 1103 + 7), "R3");
    end
    sweep("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule